// File: doc/BRIEF.md
# Byte Lane Write Mask Unit

This block turns the write strobes of a 72-bit memory data path into a per-bit write enable vector. The bus is split into nine byte lanes: eight data lanes, each with its own column strobe, and one parity lane whose eight bits are spread across the bus, one bit after each data byte. A write reaches a lane only when that lane's column strobe and the shared write strobe are both low. The enables for a data lane are set or cleared as a whole byte.

The parity lane can also be written bit by bit. When a row cycle opens (the row strobe goes from high to low), the block takes a bit mask from the parity bit positions of the data bus. From then on those pins carry ordinary write data. The captured mask gates every parity-lane write until the next row cycle opens, so a whole page burst uses one mask. A build parameter selects error-correction mode. In that mode the per-bit mask is turned off and the parity lane is written as a full byte.

All strobes are active low and are sampled on the rising clock edge. The enable vector, the write data and a valid flag are registered, so they appear one clock after the strobes that produce them.

Top module: `bl_wmask_top`

## Requirements
- R1: Lane L (0..8) is written only when `col_n[L]` and `we_n` are both low on the same clock edge. The resulting enables appear on the next cycle. If either strobe is high, that lane's enables are zero.
- R2: Data lane k (0..7) covers bus bits 9k to 9k+7, and `col_n[k]` strobes it. The parity lane is strobed by `col_n[8]`. Its bit j sits at bus position 9j+8, which gives positions 8, 17, 26, 35, 44, 53, 62 and 71.
- R3: A row cycle starts on a cycle where `row_n` is sampled low after being sampled high on the previous cycle. On that cycle, bit j of the mask is taken from `dq_in[9j+8]`.
- R4: When the per-bit mask is in use, a mask bit of 1 lets the matching parity bit be written and a mask bit of 0 blocks it.
- R5: The mask stays unchanged until the next row cycle starts. This holds while `row_n` stays low and while the parity pins carry different write data.
- R6: With `ECC_MODE=1`, a strobed parity lane has all eight parity enables set, whatever the parity pins held at the row edge.
- R7: Reset is synchronous and active high. It clears the outputs to zero and sets the mask to all ones. In ECC mode, every row start also reloads the mask to all ones.
- R8: The eight enables of a data lane are either all set or all clear. Data lanes are never masked bit by bit.
- R9: `wr_data` is `dq_in` delayed by one cycle. `wr_valid` is high when at least one lane was strobed for writing on the previous edge.
- R10: A write strobed in the same cycle as a row start uses the mask captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n | input | 1 | Row strobe, active low; a high-to-low change starts a row cycle |
| col_n | input | 9 | Column strobes, active low; bits 0..7 are the data lanes, bit 8 is the parity lane |
| we_n | input | 1 | Shared write strobe, active low |
| dq_in | input | 72 | Data bus; the parity positions carry the mask at a row start |
| wr_bit_en | output | 72 | Registered per-bit write enables |
| wr_data | output | 72 | Registered write data |
| wr_valid | output | 1 | Registered flag: at least one lane is being written |

## Verification
The hardest case to reach is the row-start cycle itself. In that cycle the parity pins serve as the mask and, when a write is strobed at the same time, as the write data too. The bench produces this by opening row cycles while all nine lanes are strobed. It also opens row cycles with no strobe and then follows them with burst writes whose parity bits differ from the captured mask. That separates a mask that is held correctly from one that is sampled again. Two instances, one per mode, get the same stimulus, so each row-start pattern is checked against both parity behaviours.

// File: rtl/bl_wmask_pkg.sv
package bl_wmask_pkg;
  // bus position of bit b inside group g, each group = lane_w data bits + 1 parity bit
  function automatic int bus_pos(input int g, input int b, input int lane_w);
    return g * (lane_w + 1) + b;
  endfunction
endpackage

// File: rtl/bl_row_edge.sv
module bl_row_edge (
  input  logic clk,
  input  logic rst,
  input  logic row_n,
  output logic row_start
);
  logic row_q;

  always_ff @(posedge clk) begin
    if (rst) row_q <= 1'b1;
    else     row_q <= row_n;
  end

  assign row_start = row_q & ~row_n;

  assert_start_edge_R3: assert property (@(posedge clk) disable iff (rst)
    row_start |-> ($past(row_n) && !row_n));
endmodule

// File: rtl/bl_mask_reg.sv
module bl_mask_reg #(
  parameter int GROUPS   = 8,
  parameter bit ECC_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_start,
  input  logic [GROUPS-1:0] par_pins,
  output logic [GROUPS-1:0] mask_eff
);
  logic [GROUPS-1:0] mask_q;
  logic [GROUPS-1:0] mask_load;

  generate
    if (ECC_MODE) begin : g_ecc
      assign mask_load = '1;
    end else begin : g_bitmask
      assign mask_load = par_pins;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '1;
    else if (row_start) mask_q <= mask_load;
  end

  // a write strobed on the row-start cycle sees the freshly sampled mask
  assign mask_eff = row_start ? mask_load : mask_q;

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !row_start |=> $stable(mask_q));
  assert_mask_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1));
  generate
    if (!ECC_MODE) begin : g_chk_cap
      assert_mask_capture_R3: assert property (@(posedge clk) disable iff (rst)
        row_start |=> (mask_q == $past(par_pins)));
    end else begin : g_chk_ecc
      assert_mask_ecc_R7: assert property (@(posedge clk) disable iff (rst)
        row_start |=> (mask_q == '1));
    end
  endgenerate
endmodule

// File: rtl/bl_lane_enable.sv
module bl_lane_enable
  import bl_wmask_pkg::*;
#(
  parameter int GROUPS   = 8,
  parameter int LANE_W   = 8,
  parameter bit ECC_MODE = 1'b0,
  localparam int LANES = GROUPS + 1,
  localparam int BUS_W = GROUPS * (LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  col_n,
  input  logic              we_n,
  input  logic [BUS_W-1:0]  dq_in,
  input  logic [GROUPS-1:0] mask_eff,
  output logic [BUS_W-1:0]  wr_bit_en,
  output logic [BUS_W-1:0]  wr_data,
  output logic              wr_valid
);
  logic [LANES-1:0]  hit;
  logic [GROUPS-1:0] par_gate;
  logic [BUS_W-1:0]  en_next;

  assign hit = ~col_n & {LANES{~we_n}};

  generate
    if (ECC_MODE) begin : g_full_par
      assign par_gate = {GROUPS{hit[GROUPS]}};
    end else begin : g_mask_par
      assign par_gate = {GROUPS{hit[GROUPS]}} & mask_eff;
    end
  endgenerate

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      for (genvar b = 0; b < LANE_W; b++) begin : g_bit
        assign en_next[bus_pos(g, b, LANE_W)] = hit[g];
      end
      assign en_next[bus_pos(g, LANE_W, LANE_W)] = par_gate[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bit_en <= '0;
      wr_data   <= '0;
      wr_valid  <= 1'b0;
    end else begin
      wr_bit_en <= en_next;
      wr_data   <= dq_in;
      wr_valid  <= |hit;
    end
  end

  assert_idle_we_R1: assert property (@(posedge clk) disable iff (rst)
    we_n |=> (wr_bit_en == '0 && !wr_valid));

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
      assert_lane_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_bit_en[bus_pos(g, 0, LANE_W)] || wr_bit_en[bus_pos(g, LANE_W-1, LANE_W)])
          |-> $past(!col_n[g] && !we_n));
      assert_lane_whole_R8: assert property (@(posedge clk) disable iff (rst)
        wr_bit_en[bus_pos(g, 0, LANE_W)] == wr_bit_en[bus_pos(g, LANE_W-1, LANE_W)]);
      assert_par_gate_R4: assert property (@(posedge clk) disable iff (rst)
        wr_bit_en[bus_pos(g, LANE_W, LANE_W)] |-> $past(!col_n[GROUPS] && !we_n));
      if (ECC_MODE) begin : g_ecc_chk
        assert_par_full_R6: assert property (@(posedge clk) disable iff (rst)
          $past(!col_n[GROUPS] && !we_n) |-> wr_bit_en[bus_pos(g, LANE_W, LANE_W)]);
      end
    end
  endgenerate

  assert_data_delay_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wr_data == $past(dq_in)));
endmodule

// File: rtl/bl_wmask_top.sv
module bl_wmask_top
  import bl_wmask_pkg::*;
#(
  parameter int GROUPS   = 8,
  parameter int LANE_W   = 8,
  parameter bit ECC_MODE = 1'b0,
  localparam int LANES = GROUPS + 1,
  localparam int BUS_W = GROUPS * (LANE_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_n,
  input  logic [LANES-1:0] col_n,
  input  logic             we_n,
  input  logic [BUS_W-1:0] dq_in,
  output logic [BUS_W-1:0] wr_bit_en,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_valid
);
  logic              row_start;
  logic [GROUPS-1:0] par_pins;
  logic [GROUPS-1:0] mask_eff;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_pins
      assign par_pins[g] = dq_in[bus_pos(g, LANE_W, LANE_W)];
    end
  endgenerate

  bl_row_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .row_n     (row_n),
    .row_start (row_start)
  );

  bl_mask_reg #(.GROUPS(GROUPS), .ECC_MODE(ECC_MODE)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .row_start (row_start),
    .par_pins  (par_pins),
    .mask_eff  (mask_eff)
  );

  bl_lane_enable #(.GROUPS(GROUPS), .LANE_W(LANE_W), .ECC_MODE(ECC_MODE)) u_lanes (
    .clk       (clk),
    .rst       (rst),
    .col_n     (col_n),
    .we_n      (we_n),
    .dq_in     (dq_in),
    .mask_eff  (mask_eff),
    .wr_bit_en (wr_bit_en),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid)
  );
endmodule

// File: tb/bl_wmask_top_test.sv
module bl_wmask_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_n = 1'b1;
  logic [8:0]  col_n = '1;
  logic        we_n = 1'b1;
  logic [71:0] dq_in = '0;
  logic [71:0] en0, en1, d0, d1;
  logic        v0, v1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bl_wmask_top #(.ECC_MODE(1'b0)) uut (
    .clk(clk), .rst(rst), .row_n(row_n), .col_n(col_n), .we_n(we_n), .dq_in(dq_in),
    .wr_bit_en(en0), .wr_data(d0), .wr_valid(v0));

  bl_wmask_top #(.ECC_MODE(1'b1)) uut_ecc (
    .clk(clk), .rst(rst), .row_n(row_n), .col_n(col_n), .we_n(we_n), .dq_in(dq_in),
    .wr_bit_en(en1), .wr_data(d1), .wr_valid(v1));

  typedef struct {
    logic [71:0] e0;
    logic [71:0] e1;
    logic [71:0] d;
    logic        v;
    string       req;
  } item_t;

  item_t sb[$];

  logic       m_prev_row = 1'b1;
  logic [7:0] m_mask = 8'hFF;

  function automatic logic [71:0] build_en(input logic [8:0] hit, input logic [7:0] pm);
    logic [71:0] e = '0;
    for (int g = 0; g < 8; g++) begin
      for (int b = 0; b < 8; b++) e[g*9+b] = hit[g];
      e[g*9+8] = hit[8] & pm[g];
    end
    return e;
  endfunction

  function automatic logic [71:0] with_par(input logic [71:0] d, input logic [7:0] m);
    logic [71:0] r = d;
    for (int j = 0; j < 8; j++) r[j*9+8] = m[j];
    return r;
  endfunction

  function automatic logic [71:0] rnd72();
    logic [95:0] r = {$urandom, $urandom, $urandom};
    return r[71:0];
  endfunction

  task automatic check(input string req, input string what, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(input logic rn, input logic [8:0] cn, input logic wn, input logic [71:0] dq, input string req);
    item_t it;
    logic [8:0] hit;
    logic [7:0] pins;
    @(negedge clk);
    row_n = rn; col_n = cn; we_n = wn; dq_in = dq;
    for (int j = 0; j < 8; j++) pins[j] = dq[j*9+8];
    if (m_prev_row && !rn) m_mask = pins;  // R3, R10: new mask applies this cycle
    m_prev_row = rn;
    hit = ~cn & {9{~wn}};
    it.e0  = build_en(hit, m_mask);
    it.e1  = build_en(hit, 8'hFF);
    it.d   = dq;
    it.v   = |hit;
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares each registered result one clock after its stimulus
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.req, "bitmask en", en0, it.e0);
        check(it.req, "ecc en", en1, it.e1);
        check("R9", "data", d0, it.d);
        check("R9", "ecc data", d1, it.d);
        check("R9", "valid", {71'd0, v0}, {71'd0, it.v});
        check("R9", "ecc valid", {71'd0, v1}, {71'd0, it.v});
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [71:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: outputs cleared during reset
    check("R7", "reset en", en0, '0);
    check("R7", "reset ecc en", en1, '0);
    check("R7", "reset valid", {71'd0, v0 | v1}, '0);
    rst = 1'b0;

    // R1: strobe without write enable, and write enable without strobes
    drive(1'b1, 9'h000, 1'b1, rnd72(), "R1");
    drive(1'b1, 9'h1FF, 1'b0, rnd72(), "R1");
    // R7: mask all ones after reset, before any row start
    drive(1'b1, 9'h000, 1'b0, rnd72(), "R7");
    // R3: row start capturing 0xA5 without writing
    drive(1'b0, 9'h1FF, 1'b1, with_par(rnd72(), 8'hA5), "R3");
    // R4, R2, R6: all lanes written under mask 0xA5
    drive(1'b0, 9'h000, 1'b0, with_par(rnd72(), 8'h5A), "R4");
    // R5: parity pins now differ; mask held
    drive(1'b0, 9'h0FF, 1'b0, with_par(rnd72(), 8'hFF), "R5");
    // R8: data lane subset 1,3,4,6
    drive(1'b0, 9'h1A5, 1'b0, rnd72(), "R8");
    drive(1'b1, 9'h1FF, 1'b1, rnd72(), "R1");
    // R10: row start with write in the same cycle, mask 0x00; ECC reload R7
    drive(1'b0, 9'h000, 1'b0, with_par(rnd72(), 8'h00), "R10");
    drive(1'b0, 9'h000, 1'b0, with_par(rnd72(), 8'h3C), "R5");
    drive(1'b1, 9'h1FF, 1'b1, rnd72(), "R1");
    // R3: new row with mask 0x81, parity lane only
    drive(1'b0, 9'h1FF, 1'b1, with_par(rnd72(), 8'h81), "R3");
    drive(1'b0, 9'h0FF, 1'b0, rnd72(), "R2");
    // R6, R4: randomized rows and bursts
    for (int n = 0; n < 40; n++) begin
      r = rnd72();
      drive(r[0], r[9:1], r[10], rnd72(), "R4");
    end
    drive(1'b1, 9'h1FF, 1'b1, '0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule